// File: doc/BRIEF.md
# Bank-Interleaved Dual-Write Register File

This block is a register file that accepts two write requests and serves three read ports in every clock cycle. Storage is divided into banks. The low bits of a register index choose the bank, and the remaining bits choose the row inside that bank. Each bank has exactly one write port, so two writes complete on the same edge only when they address different banks.

When both write requests fall in the same bank, the block raises a conflict flag in that same cycle. It then performs the write from port 0 and drops the write from port 1. The surrounding pipeline uses the flag to replay or stall the losing write. The three read ports are combinational and independent of each other. A write becomes visible from the cycle after its clock edge. The bank count is a parameter and may be 2, 4 or 8. A higher count lowers the chance of a conflict, at the cost of wider read multiplexers.

Top module: `bdrf_regfile`

## Requirements
- R1: While rst_ni is low, every register reads as zero. This holds at start-up and again after a reset issued mid-run.
- R2: The bank of a register index is its low log2(NUM_BANKS) bits. With the default of 2 banks, bit 0 of the index is the bank (0 = even, 1 = odd). conflict_o is high in the same cycle, combinationally, exactly when we0_i and we1_i are both high and the two indices have equal bank bits.
- R3: A write from either port on its own is returned by any read port from the next cycle onward.
- R4: Two writes to different banks both complete on the same clock edge.
- R5: On a conflict, the port 0 write is performed and the port 1 write is dropped. The target of port 1 keeps its old value unless it is the same index as port 0, in which case the port 0 data wins.
- R6: A port whose write enable is low changes no register. conflict_o stays low whenever either enable is low, even when the two indices share a bank.
- R7: The three read ports are independent. Each one returns the contents of any index, combinationally, including the same index as another port.
- R8: There is no bypass from write to read. A read in the cycle of a write to the same index returns the prior contents.
- R9: With NUM_BANKS = 8, the bank is bits [2:0] of the index. Indices 1 and 3 do not conflict; indices 1 and 9 do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all registers |
| we0_i | input | 1 | Write enable, port 0 (priority port) |
| wa0_i | input | ADDR_W | Write index, port 0 |
| wd0_i | input | DATA_W | Write data, port 0 |
| we1_i | input | 1 | Write enable, port 1 |
| wa1_i | input | ADDR_W | Write index, port 1 |
| wd1_i | input | DATA_W | Write data, port 1 |
| ra0_i | input | ADDR_W | Read index, port 0 |
| ra1_i | input | ADDR_W | Read index, port 1 |
| ra2_i | input | ADDR_W | Read index, port 2 |
| rd0_o | output | DATA_W | Read data, port 0 |
| rd1_o | output | DATA_W | Read data, port 1 |
| rd2_o | output | DATA_W | Read data, port 2 |
| conflict_o | output | 1 | Both writes target one bank; port 1 write dropped |

## Verification
A wrong bank decode or a wrong steering choice is visible at the ports one cycle after the write. The corrupted row reads back wrong on the very next read of that index, or on a neighbouring index in the same bank. A bad conflict decision shows up immediately on conflict_o in the same cycle. If it also lets port 1 through, that row reads back with port 1's data in the following cycle. Writes to every index, reads of every index and a mid-run reset expose wrong rows, lost writes and stale contents within one cycle of the fault.

// File: rtl/bdrf_pkg.sv
package bdrf_pkg;
  localparam int unsigned DEF_NUM_REGS  = 32;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NUM_BANKS = 2;
  localparam int unsigned NUM_RD        = 3;

  // width of an index field, at least one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bdrf_wr_steer.sv
// Decodes both write requests to banks and resolves same-bank conflicts.
module bdrf_wr_steer #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned ROW_W     = 4
) (
  input  logic                                 we0_i,
  input  logic [ADDR_W-1:0]                    wa0_i,
  input  logic [DATA_W-1:0]                    wd0_i,
  input  logic                                 we1_i,
  input  logic [ADDR_W-1:0]                    wa1_i,
  input  logic [DATA_W-1:0]                    wd1_i,
  output logic [NUM_BANKS-1:0]                 bank_we_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]      bank_row_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_wd_o,
  output logic                                 conflict_o
);
  logic [BANK_W-1:0] sel0, sel1;
  logic [ROW_W-1:0]  row0, row1;

  assign sel0 = wa0_i[BANK_W-1:0];
  assign sel1 = wa1_i[BANK_W-1:0];
  assign row0 = wa0_i[ADDR_W-1:BANK_W];
  assign row1 = wa1_i[ADDR_W-1:BANK_W];

  assign conflict_o = we0_i && we1_i && (sel0 == sel1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit0, hit1;
    assign hit0 = we0_i && (sel0 == BANK_W'(b));
    // port 1 loses the bank on conflict
    assign hit1 = we1_i && (sel1 == BANK_W'(b)) && !conflict_o;
    assign bank_we_o[b]  = hit0 || hit1;
    assign bank_row_o[b] = hit0 ? row0  : row1;
    assign bank_wd_o[b]  = hit0 ? wd0_i : wd1_i;
  end
endmodule

// File: rtl/bdrf_bank.sv
// One bank: single write port, NUM_RD combinational read ports.
module bdrf_bank #(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RD = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ROW_W-1:0]                  wrow_i,
  input  logic [DATA_W-1:0]                 wd_i,
  input  logic [NUM_RD-1:0][ROW_W-1:0]      rrow_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]     rd_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[wrow_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_o[p] = mem_q[rrow_i[p]];
  end
endmodule

// File: rtl/bdrf_rd_sel.sv
// Picks one bank's read data by the low index bits of a read address.
module bdrf_rd_sel #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BANK_W    = 1
) (
  input  logic [ADDR_W-1:0]                 ra_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rd_i,
  output logic [DATA_W-1:0]                 rd_o
);
  logic [BANK_W-1:0] sel;
  assign sel  = ra_i[BANK_W-1:0];
  assign rd_o = bank_rd_i[sel];
endmodule

// File: rtl/bdrf_regfile.sv
module bdrf_regfile #(
  parameter  int unsigned NUM_REGS  = bdrf_pkg::DEF_NUM_REGS,
  parameter  int unsigned DATA_W    = bdrf_pkg::DEF_DATA_W,
  parameter  int unsigned NUM_BANKS = bdrf_pkg::DEF_NUM_BANKS,
  localparam int unsigned ADDR_W    = bdrf_pkg::idx_bits(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we0_i,
  input  logic [ADDR_W-1:0] wa0_i,
  input  logic [DATA_W-1:0] wd0_i,
  input  logic              we1_i,
  input  logic [ADDR_W-1:0] wa1_i,
  input  logic [DATA_W-1:0] wd1_i,
  input  logic [ADDR_W-1:0] ra0_i,
  input  logic [ADDR_W-1:0] ra1_i,
  input  logic [ADDR_W-1:0] ra2_i,
  output logic [DATA_W-1:0] rd0_o,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] rd2_o,
  output logic              conflict_o
);
  localparam int unsigned NUM_RD = bdrf_pkg::NUM_RD;
  localparam int unsigned BANK_W = bdrf_pkg::idx_bits(NUM_BANKS);
  localparam int unsigned ROWS   = NUM_REGS / NUM_BANKS;
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;

  logic [NUM_BANKS-1:0]                         bank_we;
  logic [NUM_BANKS-1:0][ROW_W-1:0]              bank_row;
  logic [NUM_BANKS-1:0][DATA_W-1:0]             bank_wd;
  logic [NUM_RD-1:0][ADDR_W-1:0]                ra;
  logic [NUM_RD-1:0][ROW_W-1:0]                 rrow;
  logic [NUM_BANKS-1:0][NUM_RD-1:0][DATA_W-1:0] bank_rd;
  logic [NUM_RD-1:0][NUM_BANKS-1:0][DATA_W-1:0] port_rd;
  logic [NUM_RD-1:0][DATA_W-1:0]                rd;

  assign ra[0] = ra0_i;
  assign ra[1] = ra1_i;
  assign ra[2] = ra2_i;

  bdrf_wr_steer #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_steer (
    .we0_i     (we0_i),
    .wa0_i     (wa0_i),
    .wd0_i     (wd0_i),
    .we1_i     (we1_i),
    .wa1_i     (wa1_i),
    .wd1_i     (wd1_i),
    .bank_we_o (bank_we),
    .bank_row_o(bank_row),
    .bank_wd_o (bank_wd),
    .conflict_o(conflict_o)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_row
    assign rrow[p] = ra[p][ADDR_W-1:BANK_W];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bdrf_bank #(
      .ROWS(ROWS), .ROW_W(ROW_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)
    ) u_bank (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (bank_we[b]),
      .wrow_i(bank_row[b]),
      .wd_i  (bank_wd[b]),
      .rrow_i(rrow),
      .rd_o  (bank_rd[b])
    );
  end

  // regroup bank outputs per read port
  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        port_rd[p][b] = bank_rd[b][p];
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rsel
    bdrf_rd_sel #(
      .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
    ) u_rsel (
      .ra_i     (ra[p]),
      .bank_rd_i(port_rd[p]),
      .rd_o     (rd[p])
    );
  end

  assign rd0_o = rd[0];
  assign rd1_o = rd[1];
  assign rd2_o = rd[2];
endmodule

// File: rtl/bdrf_regfile_chk.sv
module bdrf_regfile_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we0_i,
  input logic [ADDR_W-1:0]    wa0_i,
  input logic [DATA_W-1:0]    wd0_i,
  input logic                 we1_i,
  input logic [ADDR_W-1:0]    wa1_i,
  input logic [DATA_W-1:0]    wd1_i,
  input logic [ADDR_W-1:0]    ra0_i,
  input logic [DATA_W-1:0]    rd0_o,
  input logic                 conflict_o,
  input logic [NUM_BANKS-1:0] bank_we
);
  // R6
  conflict_needs_both_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (we0_i && we1_i));

  // R5
  conflict_one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> ($countones(bank_we) == 1));

  // R4
  dual_two_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we0_i && we1_i && !conflict_o) |-> ($countones(bank_we) == 2));

  // R3
  port0_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we0_i |=> ((ra0_i != $past(wa0_i)) || (rd0_o == $past(wd0_i))));

  // R4
  port1_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we1_i && !conflict_o) |=> ((ra0_i != $past(wa1_i)) || (rd0_o == $past(wd1_i))));
endmodule

bind bdrf_regfile bdrf_regfile_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we0_i     (we0_i),
  .wa0_i     (wa0_i),
  .wd0_i     (wd0_i),
  .we1_i     (we1_i),
  .wa1_i     (wa1_i),
  .wd1_i     (wd1_i),
  .ra0_i     (ra0_i),
  .rd0_o     (rd0_o),
  .conflict_o(conflict_o),
  .bank_we   (bank_we)
);

// File: tb/tb_bdrf_regfile.sv
module tb_bdrf_regfile;
  typedef struct {
    int          kind;  // 0..2 read port, 3 conflict, 4 conflict of 8-bank copy
    string       req;
    logic [31:0] exp;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we0_i = 1'b0, we1_i = 1'b0;
  logic [4:0]  wa0_i = '0, wa1_i = '0, ra0_i = '0, ra1_i = '0, ra2_i = '0;
  logic [31:0] wd0_i = '0, wd1_i = '0;
  logic [31:0] rd0_o, rd1_o, rd2_o;
  logic        conflict_o;
  logic [31:0] b8_rd0, b8_rd1, b8_rd2;
  logic        b8_conflict;

  item_t       q[$];
  logic [31:0] mdl [32];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;

  bdrf_regfile dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we0_i(we0_i), .wa0_i(wa0_i), .wd0_i(wd0_i),
    .we1_i(we1_i), .wa1_i(wa1_i), .wd1_i(wd1_i),
    .ra0_i(ra0_i), .ra1_i(ra1_i), .ra2_i(ra2_i),
    .rd0_o(rd0_o), .rd1_o(rd1_o), .rd2_o(rd2_o),
    .conflict_o(conflict_o)
  );

  bdrf_regfile #(.NUM_BANKS(8)) dut_b8 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we0_i(we0_i), .wa0_i(wa0_i), .wd0_i(wd0_i),
    .we1_i(we1_i), .wa1_i(wa1_i), .wd1_i(wd1_i),
    .ra0_i(ra0_i), .ra1_i(ra1_i), .ra2_i(ra2_i),
    .rd0_o(b8_rd0), .rd1_o(b8_rd1), .rd2_o(b8_rd2),
    .conflict_o(b8_conflict)
  );

  // driver: applies one cycle, queues expected outputs, updates the model
  task automatic step(input logic w0, input logic [4:0] a0, input logic [31:0] d0,
                      input logic w1, input logic [4:0] a1, input logic [31:0] d1,
                      input logic [4:0] r0, input logic [4:0] r1, input logic [4:0] r2,
                      input string req);
    logic c2, c8;
    we0_i = w0; wa0_i = a0; wd0_i = d0;
    we1_i = w1; wa1_i = a1; wd1_i = d1;
    ra0_i = r0; ra1_i = r1; ra2_i = r2;
    c2 = w0 && w1 && (a0[0] == a1[0]);
    c8 = w0 && w1 && (a0[2:0] == a1[2:0]);
    q.push_back('{0, req, mdl[r0]});
    q.push_back('{1, req, mdl[r1]});
    q.push_back('{2, req, mdl[r2]});
    q.push_back('{3, req, {31'd0, c2}});
    q.push_back('{4, req, {31'd0, c8}});
    if (w0) mdl[a0] = d0;
    if (w1 && !c2) mdl[a1] = d1;
    @(negedge clk_i);
  endtask

  task automatic rd3(input logic [4:0] r0, input logic [4:0] r1, input logic [4:0] r2,
                     input string req);
    step(1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 32'd0, r0, r1, r2, req);
  endtask

  task automatic do_reset();
    we0_i = 0; we1_i = 0;
    rst_ni = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor: pops and compares before the next rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rd0_o;
          1: act = rd1_o;
          2: act = rd2_o;
          3: act = {31'd0, conflict_o};
          default: act = {31'd0, b8_conflict};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d act=%h exp=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..R9 run act=hung exp=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    rd3(5'd0, 5'd17, 5'd31, "R1 zero after reset");
    // R3 single writes, port 0 then port 1
    step(1, 5'd5, 32'hAAAA_0005, 0, 5'd0, 32'h0, 5'd5, 5'd5, 5'd5, "R8 no bypass");
    rd3(5'd5, 5'd5, 5'd5, "R3 R7 port0 write visible");
    step(0, 5'd0, 32'h0, 1, 5'd6, 32'hBBBB_0006, 5'd6, 5'd5, 5'd0, "R3 port1 write");
    rd3(5'd6, 5'd0, 5'd5, "R3 R7 port1 write visible");
    // R4 different banks
    step(1, 5'd2, 32'h1111_0002, 1, 5'd9, 32'h2222_0009, 5'd2, 5'd9, 5'd5, "R4 R8 dual write");
    rd3(5'd9, 5'd2, 5'd6, "R4 both landed");
    // R5 conflict, distinct indices in the even bank
    step(1, 5'd4, 32'h3333_0004, 1, 5'd10, 32'h4444_000A, 5'd4, 5'd10, 5'd2, "R5 R2 conflict");
    rd3(5'd4, 5'd10, 5'd4, "R5 port1 dropped");
    // R5 same index on both ports
    step(1, 5'd7, 32'h5555_0007, 1, 5'd7, 32'h6666_0007, 5'd7, 5'd9, 5'd1, "R5 same index");
    rd3(5'd7, 5'd7, 5'd9, "R5 port0 wins");
    // R6 disabled ports, same bank without conflict
    step(0, 5'd5, 32'hDEAD_0005, 1, 5'd11, 32'h7777_000B, 5'd5, 5'd11, 5'd3, "R6 we0 low");
    step(1, 5'd12, 32'h8888_000C, 0, 5'd14, 32'hDEAD_000E, 5'd5, 5'd11, 5'd12, "R6 we1 low");
    rd3(5'd5, 5'd14, 5'd12, "R6 disabled write ignored");
    // R9 eight banks vs two banks
    step(1, 5'd1, 32'h0000_1001, 1, 5'd3, 32'h0000_1003, 5'd1, 5'd3, 5'd0, "R9 R2 1 vs 3");
    step(1, 5'd1, 32'h0000_2001, 1, 5'd9, 32'h0000_2009, 5'd1, 5'd9, 5'd3, "R9 R2 1 vs 9");
    step(1, 5'd16, 32'h0000_3010, 1, 5'd24, 32'h0000_3018, 5'd16, 5'd24, 5'd1, "R9 16 vs 24");
    // R4 R7 fill every index in pairs, then read all back
    for (int i = 0; i < 32; i += 2) begin
      step(1, 5'(i), 32'h5A00_0000 + 32'(i) * 32'h0101_0101,
           1, 5'(i + 1), 32'hA500_0000 + 32'(i + 1) * 32'h0010_0301,
           5'(31 - i), 5'(i), 5'(i * 7), "R4 fill");
    end
    for (int i = 0; i < 32; i++) begin
      rd3(5'(i), 5'(31 - i), 5'(i * 13 + 3), "R7 readback");
    end
    // R1 mid-run reset
    do_reset();
    rd3(5'd0, 5'd15, 5'd31, "R1 cleared mid-run");
    rd3(5'd7, 5'd8, 5'd22, "R1 cleared mid-run");
    step(1, 5'd31, 32'hFFFF_FFFF, 1, 5'd30, 32'h0123_4567, 5'd31, 5'd30, 5'd29, "R4 after reset");
    rd3(5'd31, 5'd30, 5'd29, "R4 after reset readback");

    @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule